// File: doc/BRIEF.md
# LIN Transceiver Operating-Mode Controller

This block holds the operating mode of a LIN physical-layer device as clocked digital logic. It watches the enable and transmit-data pins together with flags for supply, temperature and remote wake-up. From these it decides whether the device is Off, in Standby, asleep, or in Normal operation. It also gates the path from the transmit-data pin to the bus driver. Analog detection, the regulator and the driver itself are outside the block. Each of them reaches the block only as a synchronized flag.

To leave Normal mode, the host drops the enable pin. The transmit path closes at once. The block then counts clock cycles. When the count reaches the opening delay, it samples the transmit-data pin. When the count reaches the closing delay, it moves to the low-power mode that the sample chose. A recessive sample selects Standby and a dominant sample selects Sleep. Whenever Normal mode is entered, transmission stays blocked until the transmit-data pin has been seen recessive.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the mode output reads Off and the transmit enable is 0. Mode codes are Off=0, Standby=1, Sleep=2 and Normal=3.
- R2: When the supply-low flag is high at a clock edge, the mode is Off after that edge, whatever the mode was before.
- R3: Off is left for Standby only at an edge where supply-good and temperature-released are both high and supply-low is low. If either of the two is low, the mode stays Off.
- R4: The over-temperature flag at an edge in Standby or Normal gives Off after that edge. In Sleep the flag has no effect.
- R5: Enable high at an edge in Sleep, or in Standby without over-temperature, gives Normal after that edge.
- R6: A wake pulse at an edge in Sleep with enable low gives Standby. In every other mode the wake pulse changes nothing.
- R7: Let k be the number of consecutive edges in Normal with enable low. The transmit enable is 0 after the first such edge. The mode stays Normal up to edge k=SEL_CLOSE-1 and changes exactly at edge k=SEL_CLOSE.
- R8: Only the transmit-data level at edge k=SEL_OPEN picks the target mode: high gives Standby and low gives Sleep. The level at any other edge of the window has no effect.
- R9: If enable returns high before edge k=SEL_CLOSE, the mode stays Normal and the count starts again from zero on the next low period.
- R10: In Normal with enable high, the transmit enable goes to 1 at the first edge, including the entry edge, where transmit-data is high. It then stays 1 whatever transmit-data does, until enable falls or Normal is left.
- R11: The transmit enable is 0 after any edge that leaves the mode at anything other than Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Mode enable pin level |
| txd_i | input | 1 | Transmit-data pin level (1 = recessive) |
| sup_low_i | input | 1 | Synchronized supply-low flag |
| sup_good_i | input | 1 | Supply-good flag |
| temp_hot_i | input | 1 | Over-temperature flag |
| temp_ok_i | input | 1 | Temperature-released flag |
| wake_i | input | 1 | Remote wake-up event pulse |
| mode_o | output | 2 | Current mode: 0 Off, 1 Standby, 2 Sleep, 3 Normal |
| tx_en_o | output | 1 | Transmit path enable |

## Verification
The bench drives transmit-data to the opposite level on every edge of the window except edge SEL_OPEN. A design that sampled at the wrong edge, or at the close of the window, would then land in the wrong low-power mode. It checks the mode on edges SEL_CLOSE-1 and SEL_CLOSE. A timer that is off by one would leave Normal early or late. It raises enable part-way through a window and then lets a full window run. A count that is not cleared would cut the second window short. It enters Normal with transmit-data dominant and sends over-temperature while asleep. A gate that does not wait for a recessive level, or a thermal path that also acts in Sleep, would show up at the ports.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;
   typedef enum logic [1:0] {
      MODE_OFF    = 2'd0,
      MODE_STBY   = 2'd1,
      MODE_SLEEP  = 2'd2,
      MODE_NORMAL = 2'd3
   } lin_mode_e;
endpackage

// File: rtl/lin_msel_timer.sv
module lin_msel_timer #(
   parameter int SEL_OPEN  = 5,
   parameter int SEL_CLOSE = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic txd_i,
   output logic close_o,
   output logic pick_stby_o
);
   localparam int CW = $clog2(SEL_CLOSE + 1);
   localparam logic [CW-1:0] OPEN_IDX  = CW'(SEL_OPEN - 1);
   localparam logic [CW-1:0] CLOSE_IDX = CW'(SEL_CLOSE - 1);

   generate
      if (SEL_OPEN < 1 || SEL_CLOSE <= SEL_OPEN) begin : g_bad_window
         $error("lin_msel_timer: need 1 <= SEL_OPEN < SEL_CLOSE");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          pick_q;

   assign close_o     = run_i && (cnt_q == CLOSE_IDX);
   assign pick_stby_o = pick_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pick_q <= 1'b1;
      end else begin
         if (!run_i || close_o) cnt_q <= '0;
         else                   cnt_q <= cnt_q + 1'b1;
         if (run_i && cnt_q == OPEN_IDX) pick_q <= txd_i;
      end
   end
endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
   import lin_mode_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      en_i,
   input  logic      sup_low_i,
   input  logic      sup_good_i,
   input  logic      temp_hot_i,
   input  logic      temp_ok_i,
   input  logic      wake_i,
   input  logic      win_close_i,
   input  logic      pick_stby_i,
   output lin_mode_e mode_q_o,
   output lin_mode_e mode_d_o,
   output logic      run_o
);
   lin_mode_e mode_q, mode_d;

   always_comb begin
      mode_d = mode_q;
      if (sup_low_i) begin
         mode_d = MODE_OFF;
      end else begin
         unique case (mode_q)
            MODE_OFF:    if (sup_good_i && temp_ok_i) mode_d = MODE_STBY;
            MODE_STBY:   if (temp_hot_i) mode_d = MODE_OFF;
                         else if (en_i) mode_d = MODE_NORMAL;
            MODE_SLEEP:  if (en_i) mode_d = MODE_NORMAL;
                         else if (wake_i) mode_d = MODE_STBY;
            MODE_NORMAL: if (temp_hot_i) mode_d = MODE_OFF;
                         else if (win_close_i)
                            mode_d = pick_stby_i ? MODE_STBY : MODE_SLEEP;
            default:     mode_d = MODE_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_OFF;
      else        mode_q <= mode_d;
   end

   assign run_o    = (mode_q == MODE_NORMAL) && !en_i;
   assign mode_q_o = mode_q;
   assign mode_d_o = mode_d;
endmodule

// File: rtl/lin_tx_gate.sv
module lin_tx_gate
   import lin_mode_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  lin_mode_e cur_mode_i,
   input  lin_mode_e nxt_mode_i,
   input  logic      en_i,
   input  logic      txd_i,
   output logic      tx_en_o
);
   logic armed_q, armed_d;

   always_comb begin
      armed_d = (nxt_mode_i == MODE_NORMAL) && en_i &&
                (txd_i || (armed_q && cur_mode_i == MODE_NORMAL));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= armed_d;
   end

   assign tx_en_o = armed_q;
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
   import lin_mode_pkg::*;
#(
   parameter int SEL_OPEN  = 5,
   parameter int SEL_CLOSE = 15
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  logic       txd_i,
   input  logic       sup_low_i,
   input  logic       sup_good_i,
   input  logic       temp_hot_i,
   input  logic       temp_ok_i,
   input  logic       wake_i,
   output logic [1:0] mode_o,
   output logic       tx_en_o
);
   lin_mode_e mode_q, mode_d;
   logic      run, win_close, pick_stby;

   lin_msel_timer #(.SEL_OPEN(SEL_OPEN), .SEL_CLOSE(SEL_CLOSE)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_i       (run),
      .txd_i       (txd_i),
      .close_o     (win_close),
      .pick_stby_o (pick_stby)
   );

   lin_mode_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_i        (en_i),
      .sup_low_i   (sup_low_i),
      .sup_good_i  (sup_good_i),
      .temp_hot_i  (temp_hot_i),
      .temp_ok_i   (temp_ok_i),
      .wake_i      (wake_i),
      .win_close_i (win_close),
      .pick_stby_i (pick_stby),
      .mode_q_o    (mode_q),
      .mode_d_o    (mode_d),
      .run_o       (run)
   );

   lin_tx_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .cur_mode_i (mode_q),
      .nxt_mode_i (mode_d),
      .en_i       (en_i),
      .txd_i      (txd_i),
      .tx_en_o    (tx_en_o)
   );

   assign mode_o = mode_q;
endmodule

// File: rtl/lin_mode_ctrl_chk.sv
module lin_mode_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       en_i,
   input logic       txd_i,
   input logic       sup_low_i,
   input logic       sup_good_i,
   input logic       temp_hot_i,
   input logic       temp_ok_i,
   input logic       wake_i,
   input logic [1:0] mode_o,
   input logic       tx_en_o
);
   localparam logic [1:0] M_OFF = 2'd0, M_STBY = 2'd1, M_SLEEP = 2'd2, M_NORM = 2'd3;

   AST_SUPPLY_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      sup_low_i |=> mode_o == M_OFF); // R2
   AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == M_OFF && !(sup_good_i && temp_ok_i)) |=> mode_o == M_OFF); // R3
   AST_HOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_o == M_STBY || mode_o == M_NORM) && temp_hot_i) |=> mode_o == M_OFF); // R4
   AST_EN_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
      (!sup_low_i && en_i && (mode_o == M_SLEEP || (mode_o == M_STBY && !temp_hot_i)))
      |=> mode_o == M_NORM); // R5
   AST_WAKE_STBY: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == M_SLEEP && wake_i && !en_i && !sup_low_i) |=> mode_o == M_STBY); // R6
   AST_TX_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en_o |-> $past(en_i)); // R7
   AST_LOWPWR_FROM_EN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_o == M_STBY || mode_o == M_SLEEP) && $past(mode_o) == M_NORM) |-> !$past(en_i)); // R8
   AST_TX_ARM_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_en_o) |-> $past(txd_i)); // R10
   AST_TX_ONLY_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en_o |-> mode_o == M_NORM); // R11
endmodule

bind lin_mode_ctrl lin_mode_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .en_i       (en_i),
   .txd_i      (txd_i),
   .sup_low_i  (sup_low_i),
   .sup_good_i (sup_good_i),
   .temp_hot_i (temp_hot_i),
   .temp_ok_i  (temp_ok_i),
   .wake_i     (wake_i),
   .mode_o     (mode_o),
   .tx_en_o    (tx_en_o)
);

// File: tb/tb_lin_mode_ctrl.sv
module tb_lin_mode_ctrl;
   localparam int OPEN  = 5;
   localparam int CLOSE = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 0, txd = 0, slow = 0, sgood = 0, hot = 0, tok = 0, wake = 0;
   logic [1:0] mode;
   logic       tx_en;

   int nvec = 0, nbad = 0;
   int m_mode = 0, m_k = 0;
   bit m_sel = 1, m_armed = 0;

   always #2 clk = ~clk;

   lin_mode_ctrl #(.SEL_OPEN(OPEN), .SEL_CLOSE(CLOSE)) dut (
      .clk(clk), .rst_n(rst_n), .en_i(en), .txd_i(txd), .sup_low_i(slow),
      .sup_good_i(sgood), .temp_hot_i(hot), .temp_ok_i(tok), .wake_i(wake),
      .mode_o(mode), .tx_en_o(tx_en));

   task automatic chk(string tag, string what, int got, int exp);
      nvec++;
      if (got != exp) begin
         nbad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
      end
   endtask

   function automatic int next_mode(int cur);
      int n = cur;
      if (slow) return 0;
      case (cur)
         0: if (sgood && tok) n = 1;
         1: if (hot) n = 0; else if (en) n = 3;
         2: if (en) n = 3; else if (wake) n = 1;
         default: if (hot) n = 0; else if (!en && m_k + 1 == CLOSE) n = m_sel ? 1 : 2;
      endcase
      return n;
   endfunction

   function automatic string tag_of(int cur);
      if (slow) return "R2";
      if (cur == 0) return "R3";
      if (hot && cur != 2) return "R4";
      if (en && cur != 3) return "R5";
      if (cur == 2 || cur == 1) return "R6";
      if (!en) return "R8";
      return "R10";
   endfunction

   task automatic model_step();
      int old = m_mode;
      int nm  = next_mode(old);
      m_armed = (nm == 3) && en && (txd || (m_armed && old == 3));
      if (old == 3 && !en && nm == 3) begin
         m_k++;
         if (m_k == OPEN) m_sel = txd;
      end else begin
         if (old == 3 && !en && m_k + 1 == OPEN) m_sel = txd;
         m_k = 0;
      end
      m_mode = nm;
   endtask

   task automatic tick(string tag);
      @(posedge clk);
      model_step();
      #1;
      chk(tag, "mode", int'(mode), m_mode);
      chk(tag, "tx_en", int'(tx_en), int'(m_armed));
      if (m_mode != 3) chk("R11", "tx_en", int'(tx_en), 0);
   endtask

   task automatic run_window(bit at_open, bit elsewhere);
      en = 0;
      for (int i = 1; i <= CLOSE; i++) begin
         txd = (i == OPEN) ? at_open : elsewhere;
         tick("R8");
         if (i == 1) chk("R7", "tx_en after en low", int'(tx_en), 0);
         if (i == CLOSE - 1) chk("R7", "mode before close", int'(mode), 3);
         if (i == CLOSE) chk("R8", "mode at close", int'(mode), at_open ? 1 : 2);
      end
   endtask

   initial begin : watchdog
      #(4 * 150000);
      nbad++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'h1a2b3c4d));
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "mode in reset", int'(mode), 0);
      chk("R1", "tx_en in reset", int'(tx_en), 0);
      rst_n = 1'b1;
      tick("R1");
      chk("R1", "mode after reset", int'(mode), 0);

      // R3: each flag alone keeps Off
      sgood = 1; tok = 0; tick("R3"); chk("R3", "off hold", int'(mode), 0);
      sgood = 0; tok = 1; tick("R3"); chk("R3", "off hold", int'(mode), 0);
      sgood = 1; tok = 1; tick("R3"); chk("R3", "off exit", int'(mode), 1);

      // R6: wake in Standby has no effect
      wake = 1; tick("R6"); chk("R6", "wake in standby", int'(mode), 1); wake = 0;

      // R5 + R10: enter Normal with dominant txd
      en = 1; txd = 0; tick("R5"); chk("R5", "normal", int'(mode), 3);
      chk("R10", "blocked while dominant", int'(tx_en), 0);
      txd = 1; tick("R10"); chk("R10", "armed on recessive", int'(tx_en), 1);
      txd = 0; tick("R10"); chk("R10", "stays armed", int'(tx_en), 1);

      // R7/R8: recessive only at open edge -> Standby
      run_window(1'b1, 1'b0);
      // R9: abort a window part-way, then a full window
      en = 1; txd = 1; tick("R5");
      en = 0;
      for (int i = 0; i < OPEN + 2; i++) tick("R9");
      en = 1; tick("R9"); chk("R9", "abort stays normal", int'(mode), 3);
      run_window(1'b0, 1'b1);
      chk("R8", "sleep chosen", int'(mode), 2);

      // R4: over-temperature ignored in Sleep
      hot = 1; tick("R4"); chk("R4", "hot in sleep", int'(mode), 2); hot = 0;
      // R6: wake in Sleep
      wake = 1; tick("R6"); chk("R6", "wake from sleep", int'(mode), 1); wake = 0;
      // R4: over-temperature in Standby
      hot = 1; tick("R4"); chk("R4", "hot in standby", int'(mode), 0); hot = 0;
      tick("R3");
      // R2: supply low in Normal
      en = 1; txd = 1; tick("R5");
      slow = 1; tick("R2"); chk("R2", "supply low", int'(mode), 0);
      chk("R11", "tx off in Off", int'(tx_en), 0); slow = 0;

      // Random phase
      for (int n = 0; n < 4000; n++) begin
         string t;
         slow  = ($urandom_range(99) < 2);
         hot   = ($urandom_range(99) < 3);
         sgood = ($urandom_range(99) < 90);
         tok   = ($urandom_range(99) < 90);
         wake  = ($urandom_range(99) < 10);
         if ($urandom_range(99) < 8) en = ~en;
         if ($urandom_range(99) < 30) txd = ~txd;
         t = tag_of(m_mode);
         tick(t);
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule